// File: doc/BRIEF.md
# Integer-N Synthesizer Divider Core

This block is the digital part of an integer-N frequency synthesizer. A reference divider runs from the crystal clock (`ref_clk_i`) and emits a one-cycle reference pulse every `R_DIV` cycles. A feedback divider runs from the oscillator feedback clock (`fb_clk_i`) and produces one event every `N_DIV` cycles. A two-flip-flop phase-frequency detector compares the two event streams. Its result drives a three-state charge-pump bit (`cp_dat_o` with enable `cp_en_o`) and a lock indicator (`lock_o`). Both ratios are fixed when the block is built.

The operate input `operate_i` selects standby or operation. When it is low, every register is cleared at once, both dividers are stopped, the comparator is held cleared, the pump output is released and lock is low. On a rising edge, the operate level passes through a two-stage synchronizer in each clock domain. The reference divider then starts alone and emits its first pulse on its second clock. Only after that pulse does the sequencer release the comparator and the feedback divider. At the same moment it raises lock and allows the pump output to drive.

Top module: `synth_div_core`

## Requirements
- R1: Once running, reference pulses repeat every `R_DIV` reference clocks (legal range 5 to 65535). With the feedback late, the pump-up drives (`cp_en_o`=1, `cp_dat_o`=1) begin exactly `R_DIV` reference periods apart.
- R2: Once released, the feedback divider produces one event every `N_DIV` feedback clocks (legal range 272 to 65535). With the feedback early, the pump-down drives begin `N_DIV` feedback periods apart, within one reference period.
- R3: While `operate_i` is low, `lock_o` and `cp_en_o` are low. This takes effect immediately when `operate_i` falls, without waiting for a clock.
- R4: Count reference edges from the first one after `operate_i` rises. `lock_o` and `cp_en_o` stay low through edge 4. The first reference pulse is produced on the second edge after the synchronizer releases the divider.
- R5: `lock_o` goes high right after edge 5. The comparator ignores the start-up pulse, so `cp_en_o` stays low until the next comparison.
- R6: Pump encoding: `cp_en_o`=1 with `cp_dat_o`=1 when the reference event leads. `cp_en_o`=1 with `cp_dat_o`=0 when the feedback event leads. `cp_en_o`=0 when neither is pending. Up and down are never pending together.
- R7: While every phase-error pulse lasts at most `LOCK_WIN` reference cycles, `lock_o` stays high.
- R8: `lock_o` falls in the cycle after a phase-error pulse exceeds `LOCK_WIN` reference cycles.
- R9: After a drop, `lock_o` returns high at the end of the first comparison whose error pulse is at most `LOCK_WIN` cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| ref_clk_i | input | 1 | Crystal reference clock |
| fb_clk_i | input | 1 | Oscillator feedback clock |
| operate_i | input | 1 | High = operate, low = standby (asynchronous clear) |
| cp_dat_o | output | 1 | Charge-pump drive level (1 = up, 0 = down) |
| cp_en_o | output | 1 | Charge-pump output enable; low = high impedance |
| lock_o | output | 1 | Lock indicator |

## Verification
Start-up timing is checked edge by edge. After `operate_i` rises half a reference cycle before edge 1, `lock_o` must read low after edges 1 to 4 and high after edges 5 and 6. A scoreboard queue holds these items and compares each one at the falling clock that follows its edge. Standby takes effect immediately, so it is checked 2 ns after `operate_i` falls. Pump-up onsets depend only on the reference count and are compared to exactly `R_DIV` × 20 ns. Pump-down onsets cross a synchronizer and are compared to `N_DIV` feedback periods with one reference period of tolerance. Lock drop and recovery are awaited with bounded windows measured in comparisons.

// File: rtl/sdc_pkg.sv
package sdc_pkg;

    // Start-up sequencer: the reference divider primes first, then the loop runs.
    typedef enum logic [0:0] {
        SEQ_PRIME = 1'b0,
        SEQ_RUN   = 1'b1
    } seq_e;

endpackage

// File: rtl/sdc_sync.sv
// Multi-stage level synchronizer with asynchronous clear.
module sdc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic arst_n,
    input  logic d,
    output logic q
);
    logic [STAGES-1:0] st_d, st_q;

    always_comb begin
        st_d = {st_q[STAGES-2:0], d};
    end

    always_ff @(posedge clk or negedge arst_n) begin
        if (!arst_n) st_q <= '0;
        else         st_q <= st_d;
    end

    assign q = st_q[STAGES-1];
endmodule

// File: rtl/sdc_ref_div.sv
// Reference divider: one-cycle pulse every R_DIV clocks, first pulse on the 2nd clock.
module sdc_ref_div #(
    parameter int R_DIV = 5
) (
    input  logic clk,
    input  logic rst_n,
    output logic pulse_o
);
    localparam int RW = (R_DIV > 2) ? $clog2(R_DIV) : 2;
    localparam logic [RW-1:0] CNT_LAST  = RW'(R_DIV - 1);
    localparam logic [RW-1:0] CNT_START = RW'(R_DIV - 2);

    typedef struct packed {
        logic [RW-1:0] cnt;
        logic          pulse;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (st_q.cnt == CNT_LAST) begin
            st_d.cnt   = '0;
            st_d.pulse = 1'b1;
        end else begin
            st_d.cnt   = st_q.cnt + 1'b1;
            st_d.pulse = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{cnt: CNT_START, pulse: 1'b0};
        else        st_q <= st_d;
    end

    assign pulse_o = st_q.pulse;
endmodule

// File: rtl/sdc_fb_div.sv
// Feedback divider: flips a toggle every N_DIV enabled clocks.
module sdc_fb_div #(
    parameter int N_DIV = 272
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic tog_o
);
    localparam int NW = $clog2(N_DIV);
    localparam logic [NW-1:0] CNT_LAST = NW'(N_DIV - 1);

    typedef struct packed {
        logic [NW-1:0] cnt;
        logic          tog;
    } st_t;

    st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (en_i) begin
            if (st_q.cnt == CNT_LAST) begin
                st_d.cnt = '0;
                st_d.tog = ~st_q.tog;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tog_o = st_q.tog;
endmodule

// File: rtl/sdc_pfd.sv
// Dual flip-flop phase-frequency detector with lock qualifier, reference-clock domain.
module sdc_pfd #(
    parameter int LOCK_WIN = 4
) (
    input  logic clk,
    input  logic rst_n,
    input  logic run_i,
    input  logic fr_i,
    input  logic fb_tog_i,
    output logic up_o,
    output logic dn_o,
    output logic ld_ok_o
);
    localparam int PW = $clog2(LOCK_WIN + 2);
    localparam logic [PW-1:0] WIN  = PW'(LOCK_WIN);
    localparam logic [PW-1:0] PMAX = PW'(LOCK_WIN + 1);

    typedef struct packed {
        logic          up;
        logic          dn;
        logic          tog;
        logic [PW-1:0] pend;
        logic          ld_ok;
    } st_t;

    st_t  st_d, st_q;
    logic fr_hit, fb_hit, up_n, dn_n, clr, pending;

    always_comb begin
        st_d    = st_q;
        fr_hit  = run_i & fr_i;
        fb_hit  = run_i & (fb_tog_i ^ st_q.tog);
        up_n    = st_q.up | fr_hit;
        dn_n    = st_q.dn | fb_hit;
        clr     = up_n & dn_n;
        pending = st_q.up | st_q.dn;

        st_d.tog = fb_tog_i;
        st_d.up  = up_n & ~clr;
        st_d.dn  = dn_n & ~clr;

        if (pending) begin
            if (st_q.pend != PMAX) st_d.pend = st_q.pend + 1'b1;
        end else begin
            st_d.pend = '0;
        end

        if (pending && (st_q.pend >= WIN)) st_d.ld_ok = 1'b0;
        else if (clr)                      st_d.ld_ok = 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '{up: 1'b0, dn: 1'b0, tog: 1'b0, pend: '0, ld_ok: 1'b1};
        else        st_q <= st_d;
    end

    assign up_o    = st_q.up;
    assign dn_o    = st_q.dn;
    assign ld_ok_o = st_q.ld_ok;
endmodule

// File: rtl/synth_div_core.sv
module synth_div_core
    import sdc_pkg::*;
#(
    parameter int N_DIV       = 272,
    parameter int R_DIV       = 5,
    parameter int LOCK_WIN    = 4,
    parameter int SYNC_STAGES = 2
) (
    input  logic ref_clk_i,
    input  logic fb_clk_i,
    input  logic operate_i,
    output logic cp_dat_o,
    output logic cp_en_o,
    output logic lock_o
);
    logic rst_x_n, rst_f_n, run_f, fr_pulse, fb_tog, fb_tog_x;
    logic pfd_up, pfd_dn, ld_ok, run;
    seq_e seq_d, seq_q;

    // Operate level brought into each domain; also the domain's clear.
    sdc_sync #(.STAGES(SYNC_STAGES)) u_sync_opr_x (
        .clk(ref_clk_i), .arst_n(operate_i), .d(1'b1), .q(rst_x_n));
    sdc_sync #(.STAGES(SYNC_STAGES)) u_sync_opr_f (
        .clk(fb_clk_i), .arst_n(operate_i), .d(1'b1), .q(rst_f_n));

    sdc_ref_div #(.R_DIV(R_DIV)) u_ref_div (
        .clk(ref_clk_i), .rst_n(rst_x_n), .pulse_o(fr_pulse));

    always_comb begin
        seq_d = seq_q;
        if (seq_q == SEQ_PRIME && fr_pulse) seq_d = SEQ_RUN;
    end

    always_ff @(posedge ref_clk_i or negedge rst_x_n) begin
        if (!rst_x_n) seq_q <= SEQ_PRIME;
        else          seq_q <= seq_d;
    end

    assign run = (seq_q == SEQ_RUN);

    // Run permission into the feedback domain, feedback toggle back out.
    sdc_sync #(.STAGES(SYNC_STAGES)) u_sync_run_f (
        .clk(fb_clk_i), .arst_n(rst_f_n), .d(run), .q(run_f));

    sdc_fb_div #(.N_DIV(N_DIV)) u_fb_div (
        .clk(fb_clk_i), .rst_n(rst_f_n), .en_i(run_f), .tog_o(fb_tog));

    sdc_sync #(.STAGES(SYNC_STAGES)) u_sync_tog_x (
        .clk(ref_clk_i), .arst_n(rst_x_n), .d(fb_tog), .q(fb_tog_x));

    sdc_pfd #(.LOCK_WIN(LOCK_WIN)) u_pfd (
        .clk(ref_clk_i), .rst_n(rst_x_n), .run_i(run), .fr_i(fr_pulse),
        .fb_tog_i(fb_tog_x), .up_o(pfd_up), .dn_o(pfd_dn), .ld_ok_o(ld_ok));

    assign cp_en_o  = run & (pfd_up | pfd_dn);
    assign cp_dat_o = run & pfd_up;
    assign lock_o   = run & ld_ok;
endmodule

// File: rtl/synth_div_core_chk.sv
module synth_div_core_chk #(
    parameter int LOCK_WIN = 4
) (
    input logic ref_clk_i,
    input logic operate_i,
    input logic rst_x_n,
    input logic run,
    input logic fr_pulse,
    input logic pfd_up,
    input logic pfd_dn,
    input logic cp_dat_o,
    input logic cp_en_o,
    input logic lock_o
);
    localparam int PW = $clog2(LOCK_WIN + 2);
    localparam logic [PW-1:0] LEN_MAX = PW'(LOCK_WIN + 1);
    localparam logic [PW-1:0] LEN_WIN = PW'(LOCK_WIN);

    logic [1:0]    cyc_q;
    logic          seen_q;
    logic [PW-1:0] len_q;

    always_ff @(posedge ref_clk_i or negedge rst_x_n) begin
        if (!rst_x_n) begin
            cyc_q  <= '0;
            seen_q <= 1'b0;
            len_q  <= '0;
        end else begin
            if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
            seen_q <= seen_q | fr_pulse;
            if (pfd_up | pfd_dn) begin
                if (len_q != LEN_MAX) len_q <= len_q + 1'b1;
            end else begin
                len_q <= '0;
            end
        end
    end

    p_standby_quiet_r3: assert property (@(posedge ref_clk_i)
        !operate_i |-> (!lock_o && !cp_en_o));

    p_first_pulse_r4: assert property (@(posedge ref_clk_i) disable iff (!rst_x_n)
        (fr_pulse && !seen_q) |-> (cyc_q == 2'd2));

    p_held_before_pulse_r5: assert property (@(posedge ref_clk_i) disable iff (!rst_x_n)
        !seen_q |-> (!lock_o && !cp_en_o));

    p_pfd_exclusive_r6: assert property (@(posedge ref_clk_i) disable iff (!rst_x_n)
        !(pfd_up && pfd_dn));

    p_drive_sign_r6: assert property (@(posedge ref_clk_i) disable iff (!rst_x_n)
        cp_en_o |-> (cp_dat_o != pfd_dn));

    p_long_error_r8: assert property (@(posedge ref_clk_i) disable iff (!rst_x_n)
        (run && (pfd_up || pfd_dn) && (len_q >= LEN_WIN)) |=> !lock_o);
endmodule

bind synth_div_core synth_div_core_chk #(.LOCK_WIN(LOCK_WIN)) u_chk (
    .ref_clk_i(ref_clk_i),
    .operate_i(operate_i),
    .rst_x_n(rst_x_n),
    .run(run),
    .fr_pulse(fr_pulse),
    .pfd_up(pfd_up),
    .pfd_dn(pfd_dn),
    .cp_dat_o(cp_dat_o),
    .cp_en_o(cp_en_o),
    .lock_o(lock_o)
);

// File: tb/synth_div_core_test.sv
`timescale 1ns/1ps
module synth_div_core_test;
    localparam int N_DIV    = 272;
    localparam int R_DIV    = 272;
    localparam int LOCK_WIN = 16;

    logic ref_clk = 1'b0;
    logic fb_clk  = 1'b0;
    logic operate = 1'b0;
    logic cp_dat, cp_en, lock;
    real  fb_half = 10.0;

    int checks   = 0;
    int failures = 0;
    int edge_no  = 0;

    typedef struct {
        int    idx;
        logic  lk;
        logic  en;
        string tag;
    } exp_t;
    exp_t sb_q[$];

    synth_div_core #(.N_DIV(N_DIV), .R_DIV(R_DIV), .LOCK_WIN(LOCK_WIN)) uut (
        .ref_clk_i(ref_clk), .fb_clk_i(fb_clk), .operate_i(operate),
        .cp_dat_o(cp_dat), .cp_en_o(cp_en), .lock_o(lock));

    always #10 ref_clk = ~ref_clk;

    initial begin
        #7;
        forever #(fb_half) fb_clk = ~fb_clk;
    end

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    // Monitor: pops scoreboard items at the falling edge after their rising edge.
    always @(negedge ref_clk) begin
        exp_t e;
        edge_no = edge_no + 1;
        if (sb_q.size() > 0 && sb_q[0].idx == edge_no) begin
            e = sb_q.pop_front();
            check(lock === e.lk && cp_en === e.en, e.tag, "lock,en at start-up edge",
                  int'({lock, cp_en}), int'({e.lk, e.en}));
        end
    end

    // Driver: raises operate and queues the expected start-up sequence.
    task automatic start_up();
        @(negedge ref_clk);
        #1;
        for (int i = 1; i <= 4; i++) sb_q.push_back('{i, 1'b0, 1'b0, "R4"});
        sb_q.push_back('{5, 1'b1, 1'b0, "R5"});
        sb_q.push_back('{6, 1'b1, 1'b0, "R5"});
        edge_no = 0;
        operate = 1'b1;
        wait (sb_q.size() == 0);
    endtask

    task automatic enter_standby();
        @(negedge ref_clk);
        #1;
        operate = 1'b0;
        #2;
        check(lock === 1'b0 && cp_en === 1'b0, "R3", "lock,en right after standby",
              int'({lock, cp_en}), 0);
        repeat (3) @(negedge ref_clk);
    endtask

    task automatic wait_lock(input logic want, input int max_cyc, output bit hit);
        hit = 1'b0;
        for (int i = 0; i < max_cyc && !hit; i++) begin
            @(negedge ref_clk);
            if (lock === want) hit = 1'b1;
        end
    endtask

    task automatic onsets(input logic want_dat, input int max_cyc,
                          output realtime dt, output bit got);
        realtime t1;
        int      n;
        logic    prev;
        n = 0; t1 = 0; dt = 0; prev = cp_en;
        for (int i = 0; i < max_cyc && n < 2; i++) begin
            @(negedge ref_clk);
            if (cp_en === 1'b1 && prev !== 1'b1 && cp_dat === want_dat) begin
                if (n == 0) t1 = $realtime;
                else        dt = $realtime - t1;
                n++;
            end
            prev = cp_en;
        end
        got = (n == 2);
    endtask

    initial begin
        #(190000 * 20);
        checks++;
        failures++;
        $display("FAIL watchdog actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        int      run_len, max_len;
        bit      lock_ok, hit, got;
        realtime dt;

        // Reset / standby state
        repeat (5) @(negedge ref_clk);
        check(lock === 1'b0, "R3", "lock in standby", int'(lock), 0);
        check(cp_en === 1'b0, "R3", "pump enable in standby", int'(cp_en), 0);

        // Matched clocks: lock must hold
        start_up();
        run_len = 0; max_len = 0; lock_ok = 1'b1;
        for (int i = 0; i < 8 * R_DIV; i++) begin
            @(negedge ref_clk);
            if (cp_en === 1'b1) run_len++; else run_len = 0;
            if (run_len > max_len) max_len = run_len;
            if (lock !== 1'b1) lock_ok = 1'b0;
        end
        check(lock_ok, "R7", "lock held with matched clocks", int'(lock_ok), 1);
        check(max_len > 0 && max_len <= LOCK_WIN, "R7", "longest error pulse",
              max_len, LOCK_WIN);

        // Feedback fast: down drives, lock drop, feedback period
        enter_standby();
        fb_half = 9.5;
        start_up();
        wait_lock(1'b0, 30 * R_DIV, hit);
        check(hit, "R8", "lock falls with fast feedback", int'(lock), 0);
        onsets(1'b0, 4 * R_DIV, dt, got);
        check(got, "R6", "down drive observed", int'(got), 1);
        check(got && (dt - N_DIV * 19.0 <= 21.0) && (N_DIV * 19.0 - dt <= 21.0),
              "R2", "spacing of down onsets (ns)", int'(dt), N_DIV * 19);

        // Feedback slow: up drives at exact reference spacing
        enter_standby();
        fb_half = 10.5;
        start_up();
        onsets(1'b1, 4 * R_DIV, dt, got);
        check(got, "R6", "up drive observed", int'(got), 1);
        check(got && (dt - R_DIV * 20.0 < 0.5) && (R_DIV * 20.0 - dt < 0.5),
              "R1", "spacing of up onsets (ns)", int'(dt), R_DIV * 20);
        wait_lock(1'b0, 10 * R_DIV, hit);
        check(hit, "R8", "lock falls with slow feedback", int'(lock), 0);

        // Drift back through zero error: lock must recover
        fb_half = 9.5;
        wait_lock(1'b1, 40 * R_DIV, hit);
        check(hit, "R9", "lock returns after a clean comparison", int'(lock), 1);

        enter_standby();
        check(cp_dat === 1'b0 && cp_en === 1'b0, "R3", "pump idle in standby",
              int'({cp_dat, cp_en}), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule